// File: doc/BRIEF.md
# Staged Codec Command Formatter

This block collects audio codec control information written one byte at a time over a simple byte-wide write port. Three staging bytes hold the pieces of a codec command. After every write to one of them, the block checks a two-bit code in the upper bits of the first staging byte. If that code matches the configured value, it packs the staging bytes into a 6-bit field and a 12-bit field. It then presents both fields on a registered output with a single-cycle valid strobe.

The same write port also loads a 16-bit buffer-size register, one byte at a time. Each write replaces only the addressed byte. The two lowest bits of the size are always cleared, so the size stays a multiple of four.

Top module: `codec_cmd_fmt`

## Requirements
- R1: While `rst_n` is low, all staging bytes, `buf_size`, `cmd_a` and `cmd_b` are zero, and `cmd_valid` stays low.
- R2: A write with `wr_addr[2]`=0 and `wr_addr[1:0]` equal to 0, 1 or 2 replaces staging byte 0, 1 or 2 with `wr_data`. The other staging bytes keep their values.
- R3: After a staging write (R2), if bits 7:6 of staging byte 0 (including the value just written) equal the valid code 2'b10, `cmd_valid` is high for exactly the one cycle that follows the write's clock edge.
- R4: After a staging write where bits 7:6 of staging byte 0 differ from 2'b10, `cmd_valid` stays low.
- R5: When `cmd_valid` is high, `cmd_a` equals `{2'b00, byte1[7:4]}` OR-ed with `byte0[5:0]`.
- R6: When `cmd_valid` is high, `cmd_b` equals `{byte1[3:0], byte2}`, where byte1 supplies the upper nibble.
- R7: A write with `wr_addr[2]`=1 loads one byte of `buf_size`, which updates on the next clock edge. `wr_addr[0]`=0 selects bits 15:8 and `wr_addr[0]`=1 selects bits 7:0. The other byte is unchanged.
- R8: After any `buf_size` write, bits 1:0 of `buf_size` read as zero, whatever data was written.
- R9: A write with `wr_addr[2]`=0 and `wr_addr[1:0]`=3 is ignored. It changes no staging byte and emits no command.
- R10: A write to `buf_size` never raises `cmd_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe, one byte per cycle |
| wr_addr | input | 3 | Bit 2 selects the size register; bits 1:0 select the staging byte or size byte |
| wr_data | input | 8 | Write data byte |
| cmd_valid | output | 1 | One-cycle command strobe |
| cmd_a | output | 6 | Command field A |
| cmd_b | output | 12 | Command field B |
| buf_size | output | 16 | Buffer size, always a multiple of 4 |

## Verification
The bench tracks the staging bytes and the size in its own model. It goes after the cases where the validity code comes from a previously stored byte 0 while another byte is written. A design that checked only the data being written, rather than the stored byte, would miss or invent commands there. Writes to the unused staging slot are mixed in, because a decoder that aliased slot 3 onto slot 2 or 0 would corrupt later commands or strobe falsely. Size writes carry random low bits and alternate between the two bytes. A design that masked the wrong byte, or reloaded both bytes, would show a wrong `buf_size` after the very next edge.

// File: rtl/codec_cmd_fmt.sv
module codec_cmd_fmt #(
  parameter int        DW        = 8,
  parameter int        AW        = 3,
  parameter logic [1:0] VALID_CODE = 2'b10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  output logic          cmd_valid,
  output logic [5:0]    cmd_a,
  output logic [11:0]   cmd_b,
  output logic [2*DW-1:0] buf_size
);

  localparam int NSTG = 3;

  logic [DW-1:0] stg_q [NSTG];
  logic [DW-1:0] stg_d [NSTG];

  wire stg_wr  = wr_en && !wr_addr[2] && (wr_addr[1:0] != 2'd3);
  wire size_wr = wr_en &&  wr_addr[2];

  for (genvar i = 0; i < NSTG; i++) begin : g_stg
    assign stg_d[i] = (stg_wr && wr_addr[1:0] == 2'(i)) ? wr_data : stg_q[i];
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) stg_q[i] <= '0;
      else        stg_q[i] <= stg_d[i];
  end

  wire       fire  = stg_wr && (stg_d[0][7:6] == VALID_CODE);
  wire [5:0] a_nxt = {2'b00, stg_d[1][7:4]} | stg_d[0][5:0];
  wire [11:0] b_nxt = {stg_d[1][3:0], stg_d[2]};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cmd_valid <= 1'b0;
      cmd_a     <= '0;
      cmd_b     <= '0;
    end else begin
      cmd_valid <= fire;
      if (fire) begin
        cmd_a <= a_nxt;
        cmd_b <= b_nxt;
      end
    end

  logic [2*DW-1:0] size_raw;
  always_comb begin
    size_raw = buf_size;
    if (wr_addr[0]) size_raw[DW-1:0]    = wr_data;
    else            size_raw[2*DW-1:DW] = wr_data;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)       buf_size <= '0;
    else if (size_wr) buf_size <= {size_raw[2*DW-1:2], 2'b00};

  AST_RESET_QUIET: assert property (@(posedge clk) !rst_n |=> !cmd_valid); // R1
  AST_CMD_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> $past(wr_en && !wr_addr[2] && wr_addr[1:0] != 2'd3)); // R3
  AST_BAD_CODE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_addr[2] && wr_addr[1:0] == 2'd0 && wr_data[7:6] != VALID_CODE) |=> !cmd_valid); // R4
  AST_FIELD_B_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> cmd_b[7:0] == stg_q[2]); // R6
  AST_SIZE_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    $past(wr_en && wr_addr[2]) |-> buf_size[1:0] == 2'b00); // R8
  AST_SIZE_HI_KEEPS_LO: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr[2] && !wr_addr[0]) |=> $stable(buf_size[7:0])); // R7
  AST_SIZE_NO_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr[2]) |=> !cmd_valid); // R10
  AST_SLOT3_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == 3'd3) |=> !cmd_valid); // R9

endmodule

// File: tb/tb_codec_cmd_fmt.sv
`timescale 1ns/1ps
module tb_codec_cmd_fmt;
  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic cmd_valid;
  logic [5:0] cmd_a;
  logic [11:0] cmd_b;
  logic [15:0] buf_size;

  int n_chk = 0, n_bad = 0;
  logic [7:0] m_stg [3];
  logic [15:0] m_size;
  logic e_valid;
  logic [5:0] e_a;
  logic [11:0] e_b;
  string e_tag;

  codec_cmd_fmt dut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .cmd_valid(cmd_valid), .cmd_a(cmd_a), .cmd_b(cmd_b),
    .buf_size(buf_size));

  always #2.5 clk = ~clk;

  initial begin
    #100000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: run hung, actual=running expected=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [5:0] fa(logic [7:0] b0, logic [7:0] b1);
    return {2'b00, b1[7:4]} | b0[5:0];
  endfunction
  function automatic logic [11:0] fb(logic [7:0] b1, logic [7:0] b2);
    return {b1[3:0], b2};
  endfunction

  task automatic check_prev();
    chk({e_tag, " cmd_valid"}, 32'(cmd_valid), 32'(e_valid));
    if (e_valid) begin
      chk("R5 cmd_a", 32'(cmd_a), 32'(e_a));
      chk("R6 cmd_b", 32'(cmd_b), 32'(e_b));
    end
    chk("R7/R8 buf_size", 32'(buf_size), 32'(m_size));
  endtask

  task automatic op(logic en, logic [2:0] ad, logic [7:0] d);
    @(negedge clk);
    check_prev();
    wr_en = en; wr_addr = ad; wr_data = d;
    e_valid = 1'b0; e_tag = "R4";
    if (en && !ad[2] && ad[1:0] != 2'd3) begin
      m_stg[ad[1:0]] = d;
      e_valid = (m_stg[0][7:6] == 2'b10);
      e_tag = e_valid ? "R3" : "R4";
      if (e_valid) begin
        e_a = fa(m_stg[0], m_stg[1]);
        e_b = fb(m_stg[1], m_stg[2]);
      end
    end else if (en && ad[2]) begin
      e_tag = "R10";
      if (ad[0]) m_size[7:0] = d; else m_size[15:8] = d;
      m_size[1:0] = 2'b00;
    end else if (en) e_tag = "R9";
  endtask

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < 3; i++) m_stg[i] = '0;
    m_size = '0; e_valid = 1'b0; e_a = '0; e_b = '0; e_tag = "R1";
    repeat (3) @(negedge clk);
    chk("R1 cmd_valid", 32'(cmd_valid), 0);
    chk("R1 cmd_a", 32'(cmd_a), 0);
    chk("R1 cmd_b", 32'(cmd_b), 0);
    chk("R1 buf_size", 32'(buf_size), 0);
    rst_n = 1'b1;
    // directed: R2 fill, R3 fire, R9 slot 3, R10 size, R8 low bits
    op(1, 3'd1, 8'hA5); op(1, 3'd2, 8'h3C);
    op(1, 3'd0, 8'h81);
    op(0, 3'd0, 8'h00);
    op(1, 3'd3, 8'hFF);
    op(1, 3'd0, 8'h41);
    op(1, 3'd4, 8'hFF); op(1, 3'd5, 8'hFF); op(1, 3'd5, 8'h07);
    op(1, 3'd0, 8'hBF); op(1, 3'd2, 8'h00); op(0, 3'd0, 8'h00);
    for (int i = 0; i < 4000; i++) begin
      logic [2:0] ad = 3'($urandom_range(0, 7));
      logic [7:0] d = 8'($urandom);
      if (ad == 3'd0 && $urandom_range(0, 1) == 1) d[7:6] = 2'b10;
      op(1'($urandom_range(0, 3) != 0), ad, d);
    end
    op(0, 3'd0, 8'h00);
    @(negedge clk); check_prev();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule